// File: doc/BRIEF.md
# Doorbell-Ordered Command Mailbox Writer

This block takes a short request from local control logic and delivers it to a co-processor as a sequence of 16-bit register writes into a mailbox window. Two request kinds exist: a tone on/off command, which makes a two-word frame, and a control-message command, which makes a fixed eighteen-word frame. The frame carries a clamped byte count, a burst selector and up to ten message bytes.

The co-processor acts on the mailbox when its word 0 (the command word) is written. For that reason the writer stores every other word before word 0. Payload words 2 and up go first, in ascending order. Word 1 follows, and word 0 is written last as the doorbell. Each write is a one-cycle strobe. After each strobe comes a fixed quiet gap, set in clock cycles, before the next strobe or before the block takes a new request.

Top module: `cmd_mailbox_writer`

## Requirements
- R1: For a frame of L words, the writer stores word i at address BASE_ADDR + 2*i. It writes words 2 to L-1 in ascending order, then word 1, then word 0, so word 0 is always the last write of a frame.
- R2: `wr_en` is high for exactly one cycle per write. Between two writes of the same frame there are exactly GAP_CYC cycles with `wr_en` low.
- R3: `req_ready` is high when the block is idle, and a request is taken at a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from that edge until GAP_CYC quiet cycles have passed after the word 0 write. Changes on the request inputs while `req_ready` is low have no effect on the writes.
- R4: A message length above MAX_MSG (10) is clamped to MAX_MSG before it is used in any frame field.
- R5: In a message frame (`req_is_msg`=1), word 1 equals the clamped length plus 2, and word 2 equals the clamped length.
- R6: In a message frame, word 3 is 16'hFFFF when `burst_en`=0. When `burst_en`=1, word 3 is 16'h0000 if `burst_val`=0 and 16'h0001 if `burst_val`=1.
- R7: A message frame is always 18 words long. Word 4+j holds byte j of `msg_bytes` (bits 8j+7:8j), zero-extended, when j is below the clamped length. Every other word from 4 to 17 is zero, whatever the unused input bytes hold.
- R8: Word 0 is {CMD_TYPE, code} with CMD_TYPE in bits 15:8. The code is MSG_CODE for a message, TONE_ON_CODE for a tone request with `tone_on`=1, and TONE_OFF_CODE for a tone request with `tone_on`=0. A tone frame (`req_is_msg`=0) is two words: word 1 = 0 at BASE_ADDR+2, then word 0.
- R9: After reset, `req_ready` is 1 and `wr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Idle, request accepted when valid |
| req_is_msg | input | 1 | 1 = control message, 0 = tone command |
| tone_on | input | 1 | Tone state for a tone command |
| msg_len | input | 8 | Requested message byte count (clamped) |
| burst_en | input | 1 | 1 = burst wanted |
| burst_val | input | 1 | Burst code when enabled |
| msg_bytes | input | 8*MAX_MSG | Message bytes, byte j in bits 8j+7:8j |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | ADDR_W | Byte address of the write |
| wr_data | output | 16 | Word written |

## Verification
The bench sweeps every message length from 0 to 13 against all three burst settings and both tone states. It fills the unused input bytes with nonzero values, so a design that copied bytes past the clamped length, or skipped the clamp at 11 to 13, would show bad words 4 to 17 or a bad word 1. Each strobe is checked at its exact cycle. A writer that rang the doorbell early, wrote payload in descending order or put word 1 after word 0 would show a wrong address at that cycle. A gap that was one cycle off, or a ready that rose before the final quiet window ended, would show up as a timing mismatch. Some requests keep `req_valid` high with altered fields while the block is busy, which catches a design that restarts or resamples its frame in mid-command.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_e;

  function automatic logic [7:0] clamp_len(input logic [7:0] len, input int unsigned max_len);
    clamp_len = (int'(len) > int'(max_len)) ? 8'(max_len) : len;
  endfunction
endpackage

// File: rtl/mbx_frame_packer.sv
module mbx_frame_packer #(
  parameter int unsigned MAX_MSG       = 10,
  parameter int unsigned IDX_W         = 5,
  parameter logic [7:0]  CMD_TYPE      = 8'h21,
  parameter logic [7:0]  MSG_CODE      = 8'h5A,
  parameter logic [7:0]  TONE_ON_CODE  = 8'h11,
  parameter logic [7:0]  TONE_OFF_CODE = 8'h12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 is_msg,
  input  logic                 tone_on,
  input  logic [7:0]           msg_len,
  input  logic                 burst_en,
  input  logic                 burst_val,
  input  logic [MAX_MSG*8-1:0] msg_bytes,
  input  logic [IDX_W-1:0]     word_idx,
  output logic [15:0]          word_data
);
  import mbx_pkg::*;

  localparam int unsigned FIRST_BYTE_WORD = 4;

  logic       is_msg_q, tone_q, ben_q, bval_q;
  logic [7:0] len_q;
  logic [7:0] bytes_q [MAX_MSG];
  logic [7:0] byte_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      is_msg_q <= 1'b0;
      tone_q   <= 1'b0;
      ben_q    <= 1'b0;
      bval_q   <= 1'b0;
      len_q    <= '0;
    end else if (load) begin
      is_msg_q <= is_msg;
      tone_q   <= tone_on;
      ben_q    <= burst_en;
      bval_q   <= burst_val;
      len_q    <= clamp_len(msg_len, MAX_MSG);
    end
  end

  // One holding register per message byte
  for (genvar g = 0; g < int'(MAX_MSG); g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) bytes_q[g] <= '0;
      else if (load) bytes_q[g] <= msg_bytes[g*8 +: 8];
    end
  end

  always_comb begin
    byte_sel = '0;
    for (int j = 0; j < int'(MAX_MSG); j++) begin
      if (int'(word_idx) == j + int'(FIRST_BYTE_WORD) && j < int'(len_q))
        byte_sel = bytes_q[j];
    end
  end

  always_comb begin
    word_data = '0;
    if (word_idx == '0) begin
      word_data = {CMD_TYPE, is_msg_q ? MSG_CODE : (tone_q ? TONE_ON_CODE : TONE_OFF_CODE)};
    end else if (is_msg_q) begin
      if (int'(word_idx) == 1)      word_data = 16'(len_q) + 16'd2;
      else if (int'(word_idx) == 2) word_data = 16'(len_q);
      else if (int'(word_idx) == 3) word_data = ben_q ? {15'b0, bval_q} : 16'hFFFF;
      else                          word_data = {8'h00, byte_sel};
    end
  end

  assert_len_clamp_R4: assert property (@(posedge clk) disable iff (rst)
    int'(len_q) <= int'(MAX_MSG));
endmodule

// File: rtl/mbx_write_sequencer.sv
module mbx_write_sequencer #(
  parameter int unsigned FRAME_WORDS = 18,
  parameter int unsigned GAP_CYC     = 625000,
  parameter int unsigned ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int unsigned IDX_W       = $clog2(FRAME_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IDX_W-1:0]  start_len,
  output logic [IDX_W-1:0]  word_idx,
  input  logic [15:0]       word_data,
  output logic              ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [15:0]       wr_data
);
  import mbx_pkg::*;

  localparam int unsigned CNT_W = $clog2(GAP_CYC + 1);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx, len, nxt_idx;
  logic             last;

  assign word_idx = idx;

  // Order: payload ascending, then word 1, then word 0 (doorbell)
  always_comb begin
    if (idx >= IDX_W'(2)) nxt_idx = (idx == len - IDX_W'(1)) ? IDX_W'(1) : idx + IDX_W'(1);
    else                  nxt_idx = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SEQ_IDLE;
      ready   <= 1'b1;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      cnt     <= '0;
      idx     <= '0;
      len     <= '0;
      last    <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (state == SEQ_IDLE) begin
        if (start) begin
          state <= SEQ_BUSY;
          ready <= 1'b0;
          cnt   <= '0;
          len   <= start_len;
          idx   <= (start_len > IDX_W'(2)) ? IDX_W'(2) : IDX_W'(1);
          last  <= 1'b0;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
      end else if (last) begin
        state <= SEQ_IDLE;
        ready <= 1'b1;
      end else begin
        wr_en   <= 1'b1;
        wr_addr <= BASE_ADDR + ADDR_W'({idx, 1'b0});
        wr_data <= word_data;
        cnt     <= CNT_W'(GAP_CYC);
        idx     <= nxt_idx;
        last    <= (idx == '0);
      end
    end
  end

  logic doorbell_seen;
  always_ff @(posedge clk) begin
    if (rst || start) doorbell_seen <= 1'b0;
    else if (wr_en && wr_addr == BASE_ADDR) doorbell_seen <= 1'b1;
  end

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
  assert_ready_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    ready |-> !wr_en);
  assert_accept_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (start && ready) |=> !ready);
  assert_doorbell_last_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> doorbell_seen);
endmodule

// File: rtl/cmd_mailbox_writer.sv
module cmd_mailbox_writer #(
  parameter int unsigned MAX_MSG       = 10,
  parameter int unsigned FRAME_WORDS   = 18,
  parameter int unsigned GAP_CYC       = 625000,
  parameter int unsigned ADDR_W        = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0100,
  parameter logic [7:0]  CMD_TYPE      = 8'h21,
  parameter logic [7:0]  MSG_CODE      = 8'h5A,
  parameter logic [7:0]  TONE_ON_CODE  = 8'h11,
  parameter logic [7:0]  TONE_OFF_CODE = 8'h12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_is_msg,
  input  logic                 tone_on,
  input  logic [7:0]           msg_len,
  input  logic                 burst_en,
  input  logic                 burst_val,
  input  logic [MAX_MSG*8-1:0] msg_bytes,
  output logic                 wr_en,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [15:0]          wr_data
);
  localparam int unsigned IDX_W     = $clog2(FRAME_WORDS + 1);
  localparam int unsigned TONE_WORDS = 2;

  logic             accept;
  logic [IDX_W-1:0] frame_len, word_idx;
  logic [15:0]      word_data;

  assign accept    = req_valid && req_ready;
  assign frame_len = req_is_msg ? IDX_W'(FRAME_WORDS) : IDX_W'(TONE_WORDS);

  mbx_frame_packer #(
    .MAX_MSG(MAX_MSG), .IDX_W(IDX_W), .CMD_TYPE(CMD_TYPE), .MSG_CODE(MSG_CODE),
    .TONE_ON_CODE(TONE_ON_CODE), .TONE_OFF_CODE(TONE_OFF_CODE)
  ) u_packer (
    .clk(clk), .rst(rst), .load(accept), .is_msg(req_is_msg), .tone_on(tone_on),
    .msg_len(msg_len), .burst_en(burst_en), .burst_val(burst_val),
    .msg_bytes(msg_bytes), .word_idx(word_idx), .word_data(word_data)
  );

  mbx_write_sequencer #(
    .FRAME_WORDS(FRAME_WORDS), .GAP_CYC(GAP_CYC), .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE_ADDR), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start(accept), .start_len(frame_len),
    .word_idx(word_idx), .word_data(word_data), .ready(req_ready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );
endmodule

// File: tb/cmd_mailbox_writer_bench.sv
`timescale 1ns/1ps
module cmd_mailbox_writer_bench;
  localparam int MAXM = 10;
  localparam int FW   = 18;
  localparam int GAP  = 3;
  localparam logic [15:0] BASE = 16'h0100;
  localparam logic [7:0] TYP = 8'h21, MCODE = 8'h5A, ONC = 8'h11, OFFC = 8'h12;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_is_msg = 1'b0, tone_on = 1'b0;
  logic [7:0] msg_len = '0;
  logic burst_en = 1'b0, burst_val = 1'b0;
  logic [MAXM*8-1:0] msg_bytes = '0;
  logic req_ready, wr_en;
  logic [15:0] wr_addr, wr_data;

  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  cmd_mailbox_writer #(
    .MAX_MSG(MAXM), .FRAME_WORDS(FW), .GAP_CYC(GAP), .ADDR_W(16), .BASE_ADDR(BASE),
    .CMD_TYPE(TYP), .MSG_CODE(MCODE), .TONE_ON_CODE(ONC), .TONE_OFF_CODE(OFFC)
  ) u_cmd_mailbox_writer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_msg(req_is_msg), .tone_on(tone_on), .msg_len(msg_len),
    .burst_en(burst_en), .burst_val(burst_val), .msg_bytes(msg_bytes),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected frame for the current command, in write order
  logic [15:0] ex_addr [FW];
  logic [15:0] ex_data [FW];
  string       ex_tag  [FW];

  task automatic run_cmd(input bit is_msg, input bit ton, input int len, input bit ben,
                         input bit bval, input int seed, input bit hold);
    logic [15:0] w [FW];
    int L, n, cl;
    cl = (len > MAXM) ? MAXM : len;
    for (int i = 0; i < FW; i++) w[i] = 16'h0000;
    if (is_msg) begin
      L = FW;
      w[0] = {TYP, MCODE};
      w[1] = 16'(cl + 2);
      w[2] = 16'(cl);
      w[3] = ben ? {15'b0, bval} : 16'hFFFF;
      for (int j = 0; j < cl; j++) w[4+j] = {8'h00, 8'((8'hA1 + j * 7 + seed) & 8'hFF)};
    end else begin
      L = 2;
      w[0] = {TYP, ton ? ONC : OFFC};
    end
    n = 0;
    for (int i = 2; i < L; i++) begin
      ex_addr[n] = BASE + 16'(2 * i); ex_data[n] = w[i];
      ex_tag[n] = (i == 2) ? ((len > MAXM) ? "R4" : "R5") : (i == 3) ? "R6" : "R7";
      n++;
    end
    ex_addr[n] = BASE + 16'd2; ex_data[n] = w[1];
    ex_tag[n] = !is_msg ? "R8" : ((len > MAXM) ? "R4" : "R5"); n++;
    ex_addr[n] = BASE;         ex_data[n] = w[0]; ex_tag[n] = "R8"; n++;

    @(negedge clk);
    check("R3 ready before request", {31'b0, req_ready}, 32'd1);
    req_valid  = 1'b1;
    req_is_msg = is_msg;
    tone_on    = ton;
    msg_len    = 8'(len);
    burst_en   = ben;
    burst_val  = bval;
    for (int j = 0; j < MAXM; j++) msg_bytes[j*8 +: 8] = 8'((8'hA1 + j * 7 + seed) & 8'hFF);
    @(posedge clk);
    @(negedge clk);
    if (hold) begin
      req_is_msg = ~is_msg; tone_on = ~ton; msg_len = 8'd3; burst_en = ~ben;
      msg_bytes = ~msg_bytes;
    end else req_valid = 1'b0;
    for (int c = 0; c <= n * (GAP + 1) + 1; c++) begin
      bit exp_wr;
      int m;
      if (c > 0) @(negedge clk);
      m = (c - 1) / (GAP + 1);
      exp_wr = (c >= 1) && ((c - 1) % (GAP + 1) == 0) && (m < n);
      check("R2 strobe timing", {31'b0, wr_en}, {31'b0, exp_wr});
      check("R3 ready timing", {31'b0, req_ready}, {31'b0, c >= n * (GAP + 1) + 1});
      if (exp_wr && wr_en) begin
        check("R1 write address", {16'b0, wr_addr}, {16'b0, ex_addr[m]});
        check({ex_tag[m], " word value"}, {16'b0, wr_data}, {16'b0, ex_data[m]});
      end
      if (hold && c == n * (GAP + 1)) req_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset ready", {31'b0, req_ready}, 32'd1);
    check("R9 reset strobe", {31'b0, wr_en}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 idle ready", {31'b0, req_ready}, 32'd1);
    check("R9 idle strobe", {31'b0, wr_en}, 32'd0);

    run_cmd(1'b0, 1'b1, 0, 1'b0, 1'b0, 0, 1'b0);   // R8 tone on
    run_cmd(1'b0, 1'b0, 5, 1'b1, 1'b1, 3, 1'b1);   // R8 tone off, R3 held valid
    for (int len = 0; len <= 13; len++) begin
      for (int b = 0; b < 3; b++) begin
        run_cmd(1'b1, 1'b0, len, b != 0, b == 2, len * 3 + b, (len + b) % 4 == 1);
      end
    end
    run_cmd(1'b1, 1'b1, 255, 1'b1, 1'b0, 9, 1'b0); // R4 extreme length
    run_cmd(1'b0, 1'b1, 0, 1'b0, 1'b0, 0, 1'b0);   // back to tone after message

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule